// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects 32 interrupt inputs and presents one active-low interrupt request to a processor. Each input has its own trigger type (low level, high level, falling edge or rising edge), a three-bit priority and an enable bit. When one or more enabled sources are pending and no interrupt is being serviced, the request output is driven low. Software reads the acknowledge register to learn the winning source. That read returns the source number times four and puts the controller in service, which releases the request line. Software closes the handler with a write to the end-of-service register. Only after that write can a new request be raised.

All access goes through a simple synchronous register bus with a byte address, separate read and write strobes, write data, and registered read data. Read data is valid in the cycle after the read strobe, and every state change takes effect at the clock edge that samples the strobe. Enable bits are changed only through separate write-one-to-set and write-one-to-clear commands. Pending latches can likewise be set or cleared from software.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1, the enable register (0x114) reads 0, every source control register reads 0, and the serviced-number register (0x110) reads 0.
- R2: The control register of source n sits at byte address 4*n. Bits 7:6 hold the trigger type and bits 2:0 hold the priority. All other bits read as 0.
- R3: A write to 0x120 sets the enable bits where the write data is 1, and a write to 0x124 clears them. Bits written as 0 keep their value. The enables read back at 0x114.
- R4: Trigger type 0 makes a source pending while its input is 0, and type 1 makes it pending while its input is 1. The pending vector reads at 0x104.
- R5: Trigger type 2 latches a pending bit on a 1-to-0 input change, and type 3 latches one on a 0-to-1 change. The bit stays set after the input returns.
- R6: 0x100 returns the raw input vector, and 0x108 returns the pending vector ANDed with the enables. irq_n goes low when that AND is nonzero and nothing is in service.
- R7: The winner is the pending, enabled source with the numerically lowest priority value. On a tie, the lower source number wins.
- R8: A read of 0x10c with a winner and nothing in service returns the winner number times 4. That read enters service, clears the winner's pending latch, drives irq_n high and makes 0x110 return the winner number.
- R9: While in service, irq_n stays high whatever is pending. Any write to 0x130 leaves service, after which irq_n can go low again.
- R10: A read of 0x10c with no pending, enabled source and nothing in service returns 0 and does not enter service.
- R11: Writing 1s to 0x128 sets the pending latches of those sources, and writing 1s to 0x12c clears them.
- R12: A qualifying input edge in the same cycle as a clear of that source's latch (by acknowledge or by software) leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_i | input | 32 | Raw interrupt inputs |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can fall in the same cycle: an edge arriving on a source and a clear of that same source's pending latch, where the clear comes from an acknowledge. The bench provokes this by raising a rising-edge input in the same bus cycle as the acknowledge read of that source. It then judges the outcome through the pending register and through a second acknowledge that must return the same source again. A randomized phase drives level inputs, priorities and enables, and compares each acknowledge value and each request level against a bench-side priority model.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int BUS_AW = 9;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam logic [BUS_AW-1:0] OFS_RAW   = 9'h100;
  localparam logic [BUS_AW-1:0] OFS_PEND  = 9'h104;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 9'h108;
  localparam logic [BUS_AW-1:0] OFS_ACK   = 9'h10C;
  localparam logic [BUS_AW-1:0] OFS_NUM   = 9'h110;
  localparam logic [BUS_AW-1:0] OFS_EN    = 9'h114;
  localparam logic [BUS_AW-1:0] OFS_ENSET = 9'h120;
  localparam logic [BUS_AW-1:0] OFS_ENCLR = 9'h124;
  localparam logic [BUS_AW-1:0] OFS_PSET  = 9'h128;
  localparam logic [BUS_AW-1:0] OFS_PCLR  = 9'h12C;
  localparam logic [BUS_AW-1:0] OFS_EOS   = 9'h130;
endpackage

// File: rtl/pic_src_cell.sv
module pic_src_cell
  import pic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  src,
  input  trig_e trig,
  input  logic  sw_set,
  input  logic  clr,
  output logic  pending
);
  logic prev_q, latch_q, latch_d;
  logic edge_hit, level_hit;

  always_comb begin
    edge_hit  = 1'b0;
    level_hit = 1'b0;
    unique case (trig)
      TRIG_LOW:  level_hit = ~src;
      TRIG_HIGH: level_hit = src;
      TRIG_FALL: edge_hit  = prev_q & ~src;
      TRIG_RISE: edge_hit  = ~prev_q & src;
      default:   level_hit = 1'b0;
    endcase
    // a new event takes precedence over any clear in the same cycle
    latch_d = latch_q;
    if (clr)               latch_d = 1'b0;
    if (sw_set | edge_hit) latch_d = 1'b1;
    pending = latch_q | level_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= src;
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]         req,
  input  logic [NSRC-1:0][PW-1:0] pri,
  output logic                    any,
  output logic [IW-1:0]           idx
);
  logic [PW-1:0] best;

  // ascending scan with strict compare: equal priority keeps the lower index
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!any || pri[i] < best)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = pri[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IW  = $clog2(NSRC),
  localparam int AW  = BUS_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_n
);
  logic [1:0]      typ_q [NSRC];
  logic [1:0]      typ_d [NSRC];
  logic [PW-1:0]   pri_q [NSRC];
  logic [PW-1:0]   pri_d [NSRC];
  logic [NSRC-1:0] en_q, en_d;
  logic            in_svc_q, in_svc_d;
  logic [IW-1:0]   svc_idx_q, svc_idx_d;
  logic            irq_n_q, irq_n_d;
  logic [31:0]     rdata_q, rdata_d;

  logic [NSRC-1:0]         pend, req, sw_set, clr;
  logic [NSRC-1:0][PW-1:0] pri_vec;
  logic                    req_any;
  logic [IW-1:0]           win_idx;
  logic                    sel_ctrl, ack_fire, eos_hit;
  logic [IW-1:0]           cidx;

  assign sel_ctrl = (bus_addr[AW-1:IW+2] == '0);
  assign cidx     = bus_addr[IW+1:2];
  assign ack_fire = bus_rd && (bus_addr == OFS_ACK) && req_any && !in_svc_q;
  assign eos_hit  = bus_wr && (bus_addr == OFS_EOS);
  assign req      = pend & en_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign sw_set[g]  = bus_wr && (bus_addr == OFS_PSET) && bus_wdata[g];
    assign clr[g]     = (bus_wr && (bus_addr == OFS_PCLR) && bus_wdata[g]) ||
                        (ack_fire && (win_idx == IW'(g)));
    assign pri_vec[g] = pri_q[g];
    pic_src_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_i[g]),
      .trig    (trig_e'(typ_q[g])),
      .sw_set  (sw_set[g]),
      .clr     (clr[g]),
      .pending (pend[g])
    );
  end

  pic_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
    .req (req),
    .pri (pri_vec),
    .any (req_any),
    .idx (win_idx)
  );

  always_comb begin
    typ_d     = typ_q;
    pri_d     = pri_q;
    en_d      = en_q;
    in_svc_d  = in_svc_q;
    svc_idx_d = svc_idx_q;
    if (bus_wr && sel_ctrl) begin
      typ_d[cidx] = bus_wdata[7:6];
      pri_d[cidx] = bus_wdata[PW-1:0];
    end
    if (bus_wr && bus_addr == OFS_ENSET) en_d = en_q | bus_wdata[NSRC-1:0];
    if (bus_wr && bus_addr == OFS_ENCLR) en_d = en_q & ~bus_wdata[NSRC-1:0];
    if (eos_hit) in_svc_d = 1'b0;
    if (ack_fire) begin
      in_svc_d  = 1'b1;
      svc_idx_d = win_idx;
    end
    irq_n_d = ~(req_any & ~in_svc_d);
  end

  always_comb begin
    rdata_d = '0;
    if (sel_ctrl) begin
      rdata_d[7:6]    = typ_q[cidx];
      rdata_d[PW-1:0] = pri_q[cidx];
    end else begin
      case (bus_addr)
        OFS_RAW:  rdata_d[NSRC-1:0] = src_i;
        OFS_PEND: rdata_d[NSRC-1:0] = pend;
        OFS_STAT: rdata_d[NSRC-1:0] = req;
        OFS_ACK: begin
          if (in_svc_q)     rdata_d[IW+1:0] = {svc_idx_q, 2'b00};
          else if (req_any) rdata_d[IW+1:0] = {win_idx, 2'b00};
        end
        OFS_NUM:  rdata_d[IW-1:0]   = svc_idx_q;
        OFS_EN:   rdata_d[NSRC-1:0] = en_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        typ_q[i] <= '0;
        pri_q[i] <= '0;
      end
      en_q      <= '0;
      in_svc_q  <= 1'b0;
      svc_idx_q <= '0;
      irq_n_q   <= 1'b1;
      rdata_q   <= '0;
    end else begin
      typ_q     <= typ_d;
      pri_q     <= pri_d;
      en_q      <= en_d;
      in_svc_q  <= in_svc_d;
      svc_idx_q <= svc_idx_d;
      irq_n_q   <= irq_n_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_n     = irq_n_q;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic              irq_n,
  input logic              in_svc_q,
  input logic              req_any,
  input logic [NSRC-1:0]   en_q
);
  a_r9_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_q |-> irq_n);

  a_r8_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_ACK && req_any && !in_svc_q) |=> (in_svc_q && irq_n));

  a_r10_empty_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == OFS_ACK && !req_any && !in_svc_q) |=> !in_svc_q);

  a_r9_eos_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == OFS_EOS) |=> !in_svc_q);

  a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENSET) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENCLR) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(req_any));
endmodule

bind prio_irq_ctrl pic_checker #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .irq_n     (irq_n),
  .in_svc_q  (in_svc_q),
  .req_any   (req_any),
  .en_q      (en_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_i = 32'hFFFF_FFFF;
  logic        irq_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [2:0] bprio [32];

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_ack(input logic [31:0] r);
    logic found = 1'b0;
    logic [2:0] best = 3'd7;
    int w = 0;
    for (int i = 0; i < 32; i++)
      if (r[i] && (!found || bprio[i] < best)) begin
        found = 1'b1; best = bprio[i]; w = i;
      end
    return found ? 32'(w * 4) : 32'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    rd(9'h114, d); chk("R1 enables", d, 0);
    rd(9'h014, d); chk("R1 ctrl5", d, 0);
    rd(9'h110, d); chk("R1 svc num", d, 0);
    rd(9'h104, d); chk("R4 low-level idle inputs high", d, 0);

    // R2 control layout
    wr(9'h01C, 32'h0000_00C5); rd(9'h01C, d); chk("R2 ctrl7", d, 32'hC5);
    wr(9'h00C, 32'hFFFF_FFFF); rd(9'h00C, d); chk("R2 ctrl3 masked bits", d, 32'hC7);
    wr(9'h00C, 0); wr(9'h01C, 0);

    // R3 enable commands
    wr(9'h120, 32'hF0); rd(9'h114, d); chk("R3 set", d, 32'hF0);
    wr(9'h124, 32'h30); rd(9'h114, d); chk("R3 clr", d, 32'hC0);
    wr(9'h120, 0);      rd(9'h114, d); chk("R3 zero write", d, 32'hC0);
    wr(9'h124, 32'hFFFF_FFFF);

    // R4 levels
    wr(9'h008, 32'h40);
    rd(9'h104, d); chk("R4 high level active", d & 32'h4, 32'h4);
    @(negedge clk) src_i[2] = 1'b0;
    rd(9'h104, d); chk("R4 high level inactive", d & 32'h4, 0);
    wr(9'h008, 0);
    rd(9'h104, d); chk("R4 low level active", d & 32'h4, 32'h4);
    @(negedge clk) src_i[2] = 1'b1;
    rd(9'h104, d); chk("R4 low level inactive", d & 32'h4, 0);

    // R5 edges
    wr(9'h010, 32'hC0); wr(9'h018, 32'h80);
    rd(9'h104, d); chk("R5 no edge yet", d & 32'h50, 0);
    @(negedge clk) src_i[4] = 1'b0;
    @(negedge clk) src_i[4] = 1'b1;
    @(negedge clk) src_i[4] = 1'b0;
    @(negedge clk) src_i[6] = 1'b0;
    @(negedge clk) src_i[6] = 1'b1;
    rd(9'h104, d); chk("R5 rise and fall latched", d & 32'h50, 32'h50);

    // R6 status and request
    rd(9'h100, d); chk("R6 raw", d, src_i);
    wr(9'h120, 32'h10);
    rd(9'h108, d); chk("R6 status", d, 32'h10);
    tick(2); chk("R6 irq low", {31'd0, irq_n}, 0);

    // R8 acknowledge
    rd(9'h10C, d); chk("R8 ack value", d, 32'd16);
    tick(1); chk("R8 irq released", {31'd0, irq_n}, 1);
    rd(9'h110, d); chk("R8 svc num", d, 32'd4);
    rd(9'h104, d); chk("R8 latch cleared", d & 32'h10, 0);

    // R9 hold until end of service
    wr(9'h120, 32'h40);
    tick(3); chk("R9 held in service", {31'd0, irq_n}, 1);
    wr(9'h130, 0);
    tick(2); chk("R9 reassert after eos", {31'd0, irq_n}, 0);
    rd(9'h10C, d); chk("R9 next ack", d, 32'd24);
    wr(9'h130, 0);
    wr(9'h124, 32'hFFFF_FFFF);

    // R7 priority and tie
    for (int i = 0; i < 32; i++) bprio[i] = 3'd0;
    bprio[8] = 3'd5; bprio[9] = 3'd2; bprio[10] = 3'd2;
    wr(9'h020, 32'h45); wr(9'h024, 32'h42); wr(9'h028, 32'h42);
    wr(9'h120, 32'h700);
    rd(9'h10C, d); chk("R7 lowest value wins, tie to lower index", d, 32'd36);
    wr(9'h130, 0);
    wr(9'h124, 32'h200);
    rd(9'h10C, d); chk("R7 next tie winner", d, 32'd40);
    wr(9'h130, 0);
    wr(9'h124, 32'hFFFF_FFFF);

    // R10 empty acknowledge
    rd(9'h10C, d); chk("R10 empty ack", d, 0);
    // R11 software set and clear
    wr(9'h128, 32'h1000); wr(9'h120, 32'h1000);
    rd(9'h104, d); chk("R11 sw set", d & 32'h1000, 32'h1000);
    tick(1); chk("R10 not in service after empty ack", {31'd0, irq_n}, 0);
    wr(9'h12C, 32'h1000);
    rd(9'h104, d); chk("R11 sw clear", d & 32'h1000, 0);
    tick(2); chk("R11 irq released after clear", {31'd0, irq_n}, 1);
    wr(9'h124, 32'hFFFF_FFFF);

    // R12 edge coincident with acknowledge of the same source
    wr(9'h038, 32'hC0);
    @(negedge clk) src_i[14] = 1'b0;
    @(negedge clk) src_i[14] = 1'b1;
    @(negedge clk) src_i[14] = 1'b0;
    wr(9'h120, 32'h4000);
    @(negedge clk);
    bus_addr = 9'h10C; bus_rd = 1'b1; src_i[14] = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
    chk("R12 ack value", d, 32'd56);
    rd(9'h104, d); chk("R12 latch survives", d & 32'h4000, 32'h4000);
    wr(9'h130, 0);
    rd(9'h10C, d); chk("R12 reacknowledged", d, 32'd56);
    wr(9'h130, 0);
    wr(9'h124, 32'hFFFF_FFFF);

    // randomized level phase
    for (int i = 0; i < 32; i++) begin
      bprio[i] = 3'($urandom_range(0, 7));
      wr(9'(i * 4), 32'h40 | 32'(bprio[i]));
    end
    wr(9'h12C, 32'hFFFF_FFFF);
    for (int it = 0; it < 300; it++) begin
      logic [31:0] en, s;
      en = $urandom & $urandom;
      s  = $urandom & $urandom;
      if (it % 10 == 0) s = 0;
      if (it % 7 == 0) begin
        int k = $urandom_range(0, 31);
        bprio[k] = 3'($urandom_range(0, 7));
        wr(9'(k * 4), 32'h40 | 32'(bprio[k]));
      end
      wr(9'h124, 32'hFFFF_FFFF); wr(9'h120, en);
      @(negedge clk) src_i = s;
      tick(2);
      chk("R6 random irq level", {31'd0, irq_n}, {31'd0, ((en & s) == 0)});
      rd(9'h10C, d); chk("R7 random ack", d, exp_ack(en & s));
      wr(9'h130, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule